// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory. It watches oversampled clock and data lines, cleans them of short pulses, and finds start and stop conditions. It shifts in the select word and compares its fixed type code and strap bits with the strap inputs. It acknowledges each byte it accepts and returns data from an internal byte array. SDA is open drain: the block only ever pulls the line low, through an output-enable.

A write transfer loads the byte pointer from the address byte. Each data byte that follows is handed to the downstream page programmer as a one-cycle strobe with its address, and it also updates the internal array model. A read transfer streams bytes from the pointer for as long as the master acknowledges. A random read is a write-mode select and an address byte, then a repeated start and a read-mode select. With a 9-bit address, one strap position of the select word carries address bit 8 and no pin is compared there.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) restarts select-word reception from any state. A rising SDA while SCL is high (stop) returns the engine to idle, with SDA released in the cycle after the stop is seen.
- R2: A select word whose upper nibble is 1010 and whose strap field matches `strap_i` (bit 3 down) is acknowledged by driving SDA low for the ninth SCL pulse. Bit 0 of the word is 1 for read and 0 for write.
- R3: On a select word with a wrong type code or wrong strap bits, the engine sends no acknowledge and ignores the bus until the next start: it writes nothing and never drives SDA.
- R4: When ADDR_W is 9, only select bits 3..2 are compared with `strap_i`. Select bit 1 becomes address bit 8 for a write-mode address load, whatever its value.
- R5: In write mode the address byte and every data byte are acknowledged. Each data byte gives one `wr_valid_o` pulse carrying the pointer and the byte, and it updates the array model.
- R6: After each written byte the pointer steps within its PAGE_BYTES-aligned page, wrapping from the last byte of the page to the first.
- R7: A read drives each byte MSB first. SDA changes only while SCL is low, and it returns the byte at the loaded address on a random read.
- R8: During a read, a master acknowledge of 0 makes the engine send the next address. The address wraps from the top of the array to 0.
- R9: After a master acknowledge of 1, SDA stays released and no data follows. The next current-address read starts at the last byte read plus one.
- R10: A pulse on SCL or SDA shorter than FILT_CYC system clocks has no effect on the transfer.
- R11: Out of reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | STRAP_W | Strap pins compared with the select word (3 bits for ADDR_W=8, 2 for ADDR_W=9) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | ADDR_W | Array address of the written byte |
| wr_data_o | output | 8 | Written byte |

## Verification
The bench builds the engine with ADDR_W=9, PAGE_BYTES=8 and FILT_CYC=4. The 9-bit address brings the address-bit-8 path and the two-bit strap compare into play. It also lets a read cross from 0x1FF to 0x000 in three bytes. An 8-byte page lets a four-byte write starting at 0x1FD wrap inside its page. The 4-clock filter sits just above the 2-clock glitches the bench injects, and a full 10-clock quarter bit still gets through.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } twi_state_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic       s0_q, s1_q, line_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q   <= 1'b1;
      s1_q   <= 1'b1;
      line_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s0_q <= line_i;
      s1_q <= s0_q;
      if (s1_q == line_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        line_q <= s1_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 8,
  parameter int FILT_CYC   = 3,
  localparam int STRAP_W   = (ADDR_W > 8) ? 2 : 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [7:0]         wr_data_o
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  // line conditioning, one filter per line
  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    twi_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  logic start_e, stop_e, rise_e, fall_e;
  twi_bus_events u_ev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_f),
    .sda_i  (sda_f),
    .start_o(start_e),
    .stop_o (stop_e),
    .rise_o (rise_e),
    .fall_o (fall_e)
  );

  twi_state_e        st_q;
  logic [3:0]        cnt_q;
  logic [7:0]        shift_q;
  logic [6:0]        tx_q;
  logic              sda_oe_q, mack_q, rd_q;
  logic [0:0]        hi_q;
  logic [ADDR_W-1:0] ptr_q, ptr_pg, addr_load;
  logic              wr_valid_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q, rdata;
  logic              sel_ok;

  // strap compare and address loading depend on the array size
  if (ADDR_W > 8) begin : g_wide
    assign sel_ok    = (shift_q[7:4] == TYPE_CODE) && (shift_q[3 -: STRAP_W] == strap_i);
    assign addr_load = {hi_q, shift_q};
  end else begin : g_narrow
    assign sel_ok    = (shift_q[7:4] == TYPE_CODE) && (shift_q[3 -: STRAP_W] == strap_i);
    assign addr_load = shift_q;
  end

  // write pointer steps inside its page
  assign ptr_pg = {ptr_q[ADDR_W-1:PG_W], ptr_q[PG_W-1:0] + 1'b1};

  twi_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_valid_q),
    .waddr_i(wr_addr_q),
    .wdata_i(wr_data_q),
    .raddr_i(ptr_q),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      tx_q       <= '0;
      sda_oe_q   <= 1'b0;
      mack_q     <= 1'b1;
      rd_q       <= 1'b0;
      hi_q       <= '0;
      ptr_q      <= '0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      if (start_e) begin
        st_q     <= ST_SEL;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_e) begin
        st_q     <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_SEL, ST_ADDR, ST_WDATA: begin
            if (rise_e) begin
              if (cnt_q < 4'd8) shift_q <= {shift_q[6:0], sda_f};
              if (cnt_q < 4'd9) cnt_q <= cnt_q + 1'b1;
            end else if (fall_e && cnt_q == 4'd8) begin
              if (st_q == ST_SEL) begin
                if (sel_ok) begin
                  sda_oe_q <= 1'b1;
                  rd_q     <= shift_q[0];
                  if (!shift_q[0]) hi_q <= shift_q[1];
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_ADDR) begin
                sda_oe_q <= 1'b1;
                ptr_q    <= addr_load;
              end else begin
                sda_oe_q   <= 1'b1;
                wr_valid_q <= 1'b1;
                wr_addr_q  <= ptr_q;
                wr_data_q  <= shift_q;
                ptr_q      <= ptr_pg;
              end
            end else if (fall_e && cnt_q == 4'd9) begin
              cnt_q <= '0;
              if (st_q == ST_SEL && rd_q) begin
                st_q     <= ST_RDATA;
                sda_oe_q <= ~rdata[7];
                tx_q     <= rdata[6:0];
                ptr_q    <= ptr_q + 1'b1;
              end else begin
                sda_oe_q <= 1'b0;
                st_q     <= (st_q == ST_SEL) ? ST_ADDR : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (rise_e) begin
              if (cnt_q == 4'd8) mack_q <= sda_f;
              if (cnt_q < 4'd9) cnt_q <= cnt_q + 1'b1;
            end else if (fall_e) begin
              if (cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
              end else if (cnt_q == 4'd9) begin
                cnt_q <= '0;
                if (!mack_q) begin
                  sda_oe_q <= ~rdata[7];
                  tx_q     <= rdata[6:0];
                  ptr_q    <= ptr_q + 1'b1;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (cnt_q != 4'd0) begin
                sda_oe_q <= ~tx_q[6];
                tx_q     <= {tx_q[5:0], 1'b0};
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o   = sda_oe_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;

  // R7
  sda_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_f);

  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_e |=> !sda_oe_q);

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_q);

  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |=> !wr_valid_q);
endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int AW = 9;
  localparam int PB = 8;
  localparam int FC = 4;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_bus;

  int total = 0;
  int bad = 0;
  int wn = 0;
  logic [AW-1:0] la [16];
  logic [7:0]    ld [16];

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  twi_mem_slave #(.ADDR_W(AW), .PAGE_BYTES(PB), .FILT_CYC(FC)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .strap_i   (strap),
    .sda_oe_o  (sda_oe),
    .wr_valid_o(wr_valid),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  always @(negedge clk) begin
    if (wr_valid && wn < 16) begin
      la[wn] = wr_addr;
      ld[wn] = wr_data;
      wn++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] sel(input logic a8, input logic rw, input logic [1:0] st);
    return {4'b1010, st, a8, rw};
  endfunction

  task automatic m_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b, input bit gl_sda, input bit gl_scl);
    sda_m = b;
    if (gl_scl) begin
      repeat (3) @(negedge clk);
      scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0;
    end
    qw(); scl_m = 1'b1; qw();
    if (gl_sda) begin
      sda_m = ~b; repeat (2) @(negedge clk); sda_m = b;
    end
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b0, 1'b0);
    read_bit(ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(mack, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    chk(wr_valid == 1'b0, "R11 no strobe", wr_valid, 0);
  endtask

  task automatic t_page_write();
    logic a;
    logic [7:0] dd [4] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    logic [AW-1:0] ea [4] = '{9'h1FD, 9'h1FE, 9'h1FF, 9'h1F8};
    m_start();
    send_byte(sel(1'b1, 1'b0, 2'b10), a);
    chk(a == 1'b0, "R2 select ack", a, 0);
    send_byte(8'hFD, a);
    chk(a == 1'b0, "R5 address ack", a, 0);
    for (int i = 0; i < 4; i++) begin
      send_byte(dd[i], a);
      chk(a == 1'b0, "R5 data ack", a, 0);
    end
    m_stop(); qw();
    chk(wn == 4, "R5 strobe count", wn, 4);
    for (int i = 0; i < 4; i++) begin
      chk(la[i] == ea[i], "R6 R4 write address", la[i], ea[i]);
      chk(ld[i] == dd[i], "R5 write data", ld[i], dd[i]);
    end
  endtask

  task automatic t_low_write();
    logic a;
    m_start();
    send_byte(sel(1'b0, 1'b0, 2'b10), a);
    send_byte(8'h00, a);
    send_byte(8'h5A, a);
    send_byte(8'h6B, a);
    m_stop(); qw();
    chk(wn == 6 && la[4] == 9'h000 && ld[4] == 8'h5A, "R4 low page write", la[4], 0);
    chk(la[5] == 9'h001 && ld[5] == 8'h6B, "R5 second byte", la[5], 1);
  endtask

  task automatic t_random_read();
    logic a;
    logic [7:0] d;
    m_start();
    send_byte(sel(1'b1, 1'b0, 2'b10), a);
    send_byte(8'hFE, a);
    m_start();
    send_byte(sel(1'b0, 1'b1, 2'b10), a);
    chk(a == 1'b0, "R2 read select ack", a, 0);
    recv_byte(1'b0, d);
    chk(d == 8'hBB, "R7 random read byte", d, 8'hBB);
    recv_byte(1'b0, d);
    chk(d == 8'hCC, "R8 sequential byte", d, 8'hCC);
    recv_byte(1'b1, d);
    chk(d == 8'h5A, "R8 wrap to zero", d, 8'h5A);
    m_stop(); qw();
    chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
  endtask

  task automatic t_cur_read();
    logic a;
    logic [7:0] d;
    m_start();
    send_byte(sel(1'b0, 1'b1, 2'b10), a);
    recv_byte(1'b1, d);
    chk(d == 8'h6B, "R9 current address read", d, 8'h6B);
    m_stop(); qw();
  endtask

  task automatic t_no_stop();
    logic a;
    logic [7:0] d;
    m_start();
    send_byte(sel(1'b0, 1'b1, 2'b10), a);
    recv_byte(1'b1, d);
    chk(d == 8'h00, "R9 unwritten byte", d, 0);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    chk(d == 8'hFF, "R9 no data after nack", d, 8'hFF);
    m_stop(); qw();
  endtask

  task automatic t_mismatch();
    logic a;
    int w0;
    w0 = wn;
    m_start();
    send_byte(sel(1'b0, 1'b0, 2'b11), a);
    chk(a == 1'b1, "R3 strap mismatch nack", a, 1);
    send_byte(8'h00, a);
    chk(a == 1'b1, "R3 ignored after mismatch", a, 1);
    send_byte(8'h99, a);
    m_stop(); qw();
    m_start();
    send_byte(8'b1011_1000, a);
    chk(a == 1'b1, "R3 type mismatch nack", a, 1);
    m_stop(); qw();
    chk(wn == w0, "R3 nothing written", wn, w0);
  endtask

  task automatic t_glitch();
    logic a;
    logic [7:0] d = 8'h3C;
    m_start();
    send_byte(sel(1'b0, 1'b0, 2'b10), a);
    send_byte(8'h10, a);
    for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b1, (i == 5));
    read_bit(a);
    chk(a == 1'b0, "R10 ack through glitches", a, 0);
    m_stop(); qw();
    chk(la[wn-1] == 9'h010 && ld[wn-1] == 8'h3C, "R10 glitched byte", ld[wn-1], 8'h3C);
  endtask

  task automatic t_restart_mid();
    logic a;
    m_start();
    send_byte(sel(1'b0, 1'b0, 2'b10), a);
    send_bit(1'b0, 1'b0, 1'b0); send_bit(1'b1, 1'b0, 1'b0);
    m_stop(); qw();
    chk(sda_oe == 1'b0, "R1 stop mid byte", sda_oe, 0);
    m_start();
    send_bit(1'b1, 1'b0, 1'b0); send_bit(1'b0, 1'b0, 1'b0); send_bit(1'b1, 1'b0, 1'b0);
    m_start();
    send_byte(sel(1'b0, 1'b0, 2'b10), a);
    chk(a == 1'b0, "R1 restart mid byte", a, 0);
    send_byte(8'h20, a);
    send_byte(8'h77, a);
    m_stop(); qw();
    chk(la[wn-1] == 9'h020 && ld[wn-1] == 8'h77, "R1 write after restart", ld[wn-1], 8'h77);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_page_write();
    t_low_write();
    t_random_read();
    t_cur_read();
    t_no_stop();
    t_mismatch();
    t_glitch();
    t_restart_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule